// File: doc/BRIEF.md
# Tiered Register Write-Protection Lock

This block stores the configuration fields of a motor-control PWM timer (dead-time value, break settings, idle and off-state choices, output polarities, per-channel compare mode and preload, and two clock-enable bits) and guards them against stray writes. A 2-bit protection level can be programmed exactly once after reset. Each level above zero freezes a larger group of fields until the next timer reset or system reset.

Software writes through a simple bus with address, 32-bit data, write enable and byte strobes. All stored fields appear as registered outputs. A write that tries to change a guarded field leaves that field untouched, raises a one-cycle reject pulse and sets a sticky status bit that software clears by writing 1. The two clock-enable bits are not frozen when guarded: they can still be set but cannot be cleared.

Register word layout (address: bits): 0: dead-time [7:0], break enable [12], break polarity [13], global output enable [14], protection level [25:24]. 1: main idle states [3:0] (bit x = channel x), complementary idle states [7:4], idle off-state select [8], run off-state select [9]. 2: main polarity [3:0], complementary polarity [7:4]. 3: channel x in byte x, output mode [8x+2:8x], preload enable [8x+3]. 4: timer clock enable [0], clock-monitor enable [1]. 5: sticky violation status [0]. Other addresses are ignored.

Top module: `wp_lock_top`

## Requirements
- R1: The protection level field (address 0, bits [25:24], byte 3) takes only the first write after reset; every later write to it leaves the level unchanged until reset.
- R2: Level codes are 00 open, 01 level 1, 10 level 2, 11 level 3; at level 1 or above, dead-time, main and complementary idle states, break enable, break polarity and global output enable cannot change.
- R3: At level 2 or above, main and complementary polarity and both off-state selects are also frozen, and the two clock-enable bits become set-only; below level 2 they are freely writable.
- R4: At level 3, each channel's output mode and preload enable are also frozen; below level 3 they are freely writable, each channel on its own byte strobe.
- R5: While guarded, a clock-enable bit may go from 0 to 1 but a write of 0 does not clear it; when unguarded both directions work.
- R6: A write touching guarded and unguarded fields of one word updates the unguarded fields and keeps the guarded ones.
- R7: Only bytes whose strobe is 1 are written; unstrobed bytes neither change fields nor count as violations.
- R8: wr_reject_o is high for exactly the cycle after a write that would change a guarded field (a differing value, clearing a set-only bit, or a differing level after the level was taken); a write of equal values is not rejected.
- R9: viol_sticky_o sets together with wr_reject_o and stays set until a write to address 5 with strobe 0 and data bit 0 equal to 1; writing 0 there has no effect.
- R10: A system reset (rst) or a timer reset (tmr_rst), both synchronous and active high, clears every field, the level, the taken flag and the status to 0.
- R11: Fields written in the same cycle as the first level write are judged by the level in force before that write.
- R12: Writing 00 as the first level write uses up the single write: the level stays 00 and later level writes are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| tmr_rst | input | 1 | Synchronous timer reset, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte strobes |
| lock_level_o | output | 2 | Current protection level |
| dead_time_o | output | 8 | Dead-time value |
| brk_en_o | output | 1 | Break enable |
| brk_pol_o | output | 1 | Break polarity |
| out_en_o | output | 1 | Global output enable |
| idle_main_o | output | 4 | Main output idle state per channel |
| idle_comp_o | output | 4 | Complementary output idle state per channel |
| off_idle_o | output | 1 | Off-state select in idle mode |
| off_run_o | output | 1 | Off-state select in run mode |
| pol_main_o | output | 4 | Main output polarity per channel |
| pol_comp_o | output | 4 | Complementary output polarity per channel |
| ch_mode_o | output | 12 | Output mode per channel, channel x at [3x+2:3x] |
| ch_pre_o | output | 4 | Compare preload enable per channel |
| tmr_clk_en_o | output | 1 | Timer clock enable |
| clk_mon_en_o | output | 1 | Clock-monitor enable |
| wr_reject_o | output | 1 | One-cycle pulse for a rejected write |
| viol_sticky_o | output | 1 | Sticky violation status |

## Verification
The hardest state to reach is a set-only clock bit that already holds 1 under level 2 while a single write both clears it and sets its neighbour, since that needs the bit set before the level is taken and the level written in a separate cycle. The stimulus resets the timer, sets one clock bit while open, takes level 2, then writes the mixed pattern and checks that one bit rises, the other holds and the write is rejected. The same-cycle case of a first level write with a guarded field change is driven directly with a multi-byte strobe.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam int NCH    = 4;
  localparam int DW     = 32;
  localparam int AW     = 4;
  localparam int NB     = DW / 8;
  localparam int DT_W   = 8;
  localparam int MODE_W = 3;
  localparam int LVL_W  = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_OPEN = 2'd0,
    LVL_1    = 2'd1,
    LVL_2    = 2'd2,
    LVL_3    = 2'd3
  } lvl_e;

  localparam logic [AW-1:0] A_CTL  = 4'd0;
  localparam logic [AW-1:0] A_IDLE = 4'd1;
  localparam logic [AW-1:0] A_POL  = 4'd2;
  localparam logic [AW-1:0] A_CH   = 4'd3;
  localparam logic [AW-1:0] A_CLK  = 4'd4;
  localparam logic [AW-1:0] A_STAT = 4'd5;

  localparam int B_BRK_EN  = 12;
  localparam int B_BRK_POL = 13;
  localparam int B_OE      = 14;
  localparam int B_LVL     = 24;
  localparam int LVL_BYTE  = B_LVL / 8;
  localparam int B_OFF_I   = 8;
  localparam int B_OFF_R   = 9;
  localparam int B_COMP    = 4;
endpackage

// File: rtl/wp_field.sv
module wp_field
  import wp_lock_pkg::*;
#(
  parameter int   W        = 1,
  parameter bit   SET_ONLY = 1'b0,
  parameter lvl_e NEED     = LVL_1
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             wr,
  input  logic [W-1:0]     wd,
  input  logic [LVL_W-1:0] level,
  output logic [W-1:0]     q,
  output logic             viol
);
  logic locked;
  assign locked = (level >= NEED);

  always_comb begin
    if (SET_ONLY) viol = wr && locked && (|(q & ~wd));
    else          viol = wr && locked && (wd != q);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      q <= '0;
    end else if (wr) begin
      if (!locked)      q <= wd;
      else if (SET_ONLY) q <= q | wd;
    end
  end

  generate
    if (SET_ONLY) begin : g_setonly
      // R5
      no_clear_chk: assert property (@(posedge clk) disable iff (srst)
        locked |=> ((~q & $past(q)) == '0));
    end else begin : g_frozen
      // R2 R3 R4
      frozen_chk: assert property (@(posedge clk) disable iff (srst)
        locked |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wp_lock_pkg::*;
(
  input  logic             clk,
  input  logic             srst,
  input  logic             wr,
  input  logic [LVL_W-1:0] wd,
  output logic [LVL_W-1:0] level,
  output logic             viol
);
  logic taken;

  always_ff @(posedge clk) begin
    if (srst) begin
      level <= LVL_OPEN;
      taken <= 1'b0;
    end else if (wr && !taken) begin
      level <= wd;
      taken <= 1'b1;
    end
  end

  assign viol = wr && taken && (wd != level);

  // R1
  level_frozen_chk: assert property (@(posedge clk) disable iff (srst)
    taken |=> $stable(level));

  // R12
  taken_on_write_chk: assert property (@(posedge clk) disable iff (srst)
    wr |=> taken);
endmodule

// File: rtl/wp_viol_status.sv
module wp_viol_status (
  input  logic clk,
  input  logic srst,
  input  logic viol,
  input  logic clr,
  output logic reject,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (srst) begin
      reject <= 1'b0;
      sticky <= 1'b0;
    end else begin
      reject <= viol;
      sticky <= viol | (sticky & ~clr);
    end
  end

  // R8
  reject_sets_sticky_chk: assert property (@(posedge clk) disable iff (srst)
    reject |-> sticky);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (sticky && !clr && !viol) |=> sticky);
endmodule

// File: rtl/wp_lock_top.sv
module wp_lock_top
  import wp_lock_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tmr_rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [NB-1:0]           wr_be,
  output logic [LVL_W-1:0]        lock_level_o,
  output logic [DT_W-1:0]         dead_time_o,
  output logic                    brk_en_o,
  output logic                    brk_pol_o,
  output logic                    out_en_o,
  output logic [NCH-1:0]          idle_main_o,
  output logic [NCH-1:0]          idle_comp_o,
  output logic                    off_idle_o,
  output logic                    off_run_o,
  output logic [NCH-1:0]          pol_main_o,
  output logic [NCH-1:0]          pol_comp_o,
  output logic [NCH*MODE_W-1:0]   ch_mode_o,
  output logic [NCH-1:0]          ch_pre_o,
  output logic                    tmr_clk_en_o,
  output logic                    clk_mon_en_o,
  output logic                    wr_reject_o,
  output logic                    viol_sticky_o
);
  localparam int NV     = 8 + 6 * NCH;
  localparam int V_CH0  = 8;
  localparam int CH_STR = 8;

  logic srst;
  assign srst = rst | tmr_rst;

  logic hit_ctl, hit_idle, hit_pol, hit_ch, hit_clk, hit_stat;
  assign hit_ctl  = wr_en && (wr_addr == A_CTL);
  assign hit_idle = wr_en && (wr_addr == A_IDLE);
  assign hit_pol  = wr_en && (wr_addr == A_POL);
  assign hit_ch   = wr_en && (wr_addr == A_CH);
  assign hit_clk  = wr_en && (wr_addr == A_CLK);
  assign hit_stat = wr_en && (wr_addr == A_STAT);

  logic unused_bits;
  assign unused_bits = ^wr_data;

  logic [LVL_W-1:0] level;
  logic             lvl_viol;
  logic [NV-1:0]    fv;

  wp_lock_ctrl u_lock (
    .clk   (clk),
    .srst  (srst),
    .wr    (hit_ctl && wr_be[LVL_BYTE]),
    .wd    (wr_data[B_LVL +: LVL_W]),
    .level (level),
    .viol  (lvl_viol)
  );
  assign lock_level_o = level;

  wp_field #(.W(DT_W), .NEED(LVL_1)) u_dt (
    .clk(clk), .srst(srst), .wr(hit_ctl && wr_be[0]),
    .wd(wr_data[DT_W-1:0]), .level(level), .q(dead_time_o), .viol(fv[0]));

  wp_field #(.W(1), .NEED(LVL_1)) u_brk_en (
    .clk(clk), .srst(srst), .wr(hit_ctl && wr_be[B_BRK_EN/8]),
    .wd(wr_data[B_BRK_EN]), .level(level), .q(brk_en_o), .viol(fv[1]));

  wp_field #(.W(1), .NEED(LVL_1)) u_brk_pol (
    .clk(clk), .srst(srst), .wr(hit_ctl && wr_be[B_BRK_POL/8]),
    .wd(wr_data[B_BRK_POL]), .level(level), .q(brk_pol_o), .viol(fv[2]));

  wp_field #(.W(1), .NEED(LVL_1)) u_oe (
    .clk(clk), .srst(srst), .wr(hit_ctl && wr_be[B_OE/8]),
    .wd(wr_data[B_OE]), .level(level), .q(out_en_o), .viol(fv[3]));

  wp_field #(.W(1), .NEED(LVL_2)) u_off_idle (
    .clk(clk), .srst(srst), .wr(hit_idle && wr_be[B_OFF_I/8]),
    .wd(wr_data[B_OFF_I]), .level(level), .q(off_idle_o), .viol(fv[4]));

  wp_field #(.W(1), .NEED(LVL_2)) u_off_run (
    .clk(clk), .srst(srst), .wr(hit_idle && wr_be[B_OFF_R/8]),
    .wd(wr_data[B_OFF_R]), .level(level), .q(off_run_o), .viol(fv[5]));

  wp_field #(.W(1), .SET_ONLY(1'b1), .NEED(LVL_2)) u_tmr_clk (
    .clk(clk), .srst(srst), .wr(hit_clk && wr_be[0]),
    .wd(wr_data[0]), .level(level), .q(tmr_clk_en_o), .viol(fv[6]));

  wp_field #(.W(1), .SET_ONLY(1'b1), .NEED(LVL_2)) u_clk_mon (
    .clk(clk), .srst(srst), .wr(hit_clk && wr_be[0]),
    .wd(wr_data[1]), .level(level), .q(clk_mon_en_o), .viol(fv[7]));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int VB = V_CH0 + 6 * c;

      wp_field #(.W(1), .NEED(LVL_1)) u_idle_m (
        .clk(clk), .srst(srst), .wr(hit_idle && wr_be[c/8]),
        .wd(wr_data[c]), .level(level), .q(idle_main_o[c]), .viol(fv[VB]));

      wp_field #(.W(1), .NEED(LVL_1)) u_idle_c (
        .clk(clk), .srst(srst), .wr(hit_idle && wr_be[(B_COMP+c)/8]),
        .wd(wr_data[B_COMP+c]), .level(level), .q(idle_comp_o[c]), .viol(fv[VB+1]));

      wp_field #(.W(1), .NEED(LVL_2)) u_pol_m (
        .clk(clk), .srst(srst), .wr(hit_pol && wr_be[c/8]),
        .wd(wr_data[c]), .level(level), .q(pol_main_o[c]), .viol(fv[VB+2]));

      wp_field #(.W(1), .NEED(LVL_2)) u_pol_c (
        .clk(clk), .srst(srst), .wr(hit_pol && wr_be[(B_COMP+c)/8]),
        .wd(wr_data[B_COMP+c]), .level(level), .q(pol_comp_o[c]), .viol(fv[VB+3]));

      wp_field #(.W(MODE_W), .NEED(LVL_3)) u_mode (
        .clk(clk), .srst(srst), .wr(hit_ch && wr_be[c]),
        .wd(wr_data[CH_STR*c +: MODE_W]), .level(level),
        .q(ch_mode_o[MODE_W*c +: MODE_W]), .viol(fv[VB+4]));

      wp_field #(.W(1), .NEED(LVL_3)) u_pre (
        .clk(clk), .srst(srst), .wr(hit_ch && wr_be[c]),
        .wd(wr_data[CH_STR*c + MODE_W]), .level(level),
        .q(ch_pre_o[c]), .viol(fv[VB+5]));
    end
  endgenerate

  wp_viol_status u_stat (
    .clk    (clk),
    .srst   (srst),
    .viol   ((|fv) | lvl_viol),
    .clr    (hit_stat && wr_be[0] && wr_data[0]),
    .reject (wr_reject_o),
    .sticky (viol_sticky_o)
  );

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    srst |=> (lock_level_o == '0 && dead_time_o == '0 && !viol_sticky_o));
endmodule

// File: tb/test_wp_lock_top.sv
module test_wp_lock_top;
  import wp_lock_pkg::*;

  logic clk = 1'b0, rst = 1'b1, tmr_rst = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be = '0;
  logic [1:0] lock_level_o;
  logic [7:0] dead_time_o;
  logic brk_en_o, brk_pol_o, out_en_o, off_idle_o, off_run_o;
  logic [3:0] idle_main_o, idle_comp_o, pol_main_o, pol_comp_o, ch_pre_o;
  logic [11:0] ch_mode_o;
  logic tmr_clk_en_o, clk_mon_en_o, wr_reject_o, viol_sticky_o;

  always #2 clk = ~clk;

  wp_lock_top i_wp_lock_top (.*);

  typedef struct { int cyc; int sel; logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  int cnt = 0, total = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cnt <= cnt + 1;

  function automatic logic [31:0] obs(int sel);
    case (sel)
      0: return 32'(dead_time_o);   1: return 32'(brk_en_o);
      2: return 32'(brk_pol_o);     3: return 32'(out_en_o);
      4: return 32'(idle_main_o);   5: return 32'(idle_comp_o);
      6: return 32'(off_idle_o);    7: return 32'(off_run_o);
      8: return 32'(pol_main_o);    9: return 32'(pol_comp_o);
      10: return 32'(ch_mode_o);    11: return 32'(ch_pre_o);
      12: return 32'(tmr_clk_en_o); 13: return 32'(clk_mon_en_o);
      14: return 32'(lock_level_o); 15: return 32'(wr_reject_o);
      default: return 32'(viol_sticky_o);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cnt) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (it.cyc != cnt || obs(it.sel) !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, obs(it.sel), it.exp);
      end
    end
  end

  task automatic expect_at(int sel, logic [31:0] v, string req, int dly = 0);
    item_t it;
    it.cyc = cnt + dly; it.sel = sel; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic do_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic pulse(bit sys);
    @(negedge clk);
    if (sys) rst = 1'b1; else tmr_rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; tmr_rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10 reset state
    for (int s = 0; s <= 16; s++) expect_at(s, 32'h0, "R10");

    // open: everything writable
    do_wr(A_CTL, 32'h0000_70A5, 4'b0011);
    expect_at(0, 32'hA5, "R2"); expect_at(1, 1, "R2"); expect_at(3, 1, "R2");
    expect_at(15, 0, "R8"); expect_at(14, 0, "R1");
    do_wr(A_IDLE, 32'h0000_035A, 4'b0011);
    expect_at(4, 4'hA, "R2"); expect_at(5, 4'h5, "R2"); expect_at(6, 1, "R3"); expect_at(7, 1, "R3");
    do_wr(A_POL, 32'h0000_00C3, 4'b0001);
    expect_at(8, 4'h3, "R3"); expect_at(9, 4'hC, "R3");
    do_wr(A_CH, 32'h0C0B_0A09, 4'b1111);
    expect_at(10, 12'h8D1, "R4"); expect_at(11, 4'hF, "R4");
    do_wr(A_CLK, 32'h3, 4'b0001);
    expect_at(12, 1, "R5"); expect_at(13, 1, "R5");
    do_wr(A_CLK, 32'h0, 4'b0001);
    expect_at(12, 0, "R5"); expect_at(13, 0, "R5");

    // R7 strobes
    do_wr(A_CTL, 32'h0000_0055, 4'b0001);
    expect_at(0, 32'h55, "R7"); expect_at(1, 1, "R7"); expect_at(3, 1, "R7");
    do_wr(A_CH, 32'h0000_0000, 4'b0010);
    expect_at(10, 12'h8C1, "R7"); expect_at(11, 4'hD, "R7");

    // R11 level 1 taken with dead-time change in same write
    do_wr(A_CTL, 32'h0100_7011, 4'b1011);
    expect_at(0, 32'h11, "R11"); expect_at(14, 1, "R11"); expect_at(15, 0, "R11");

    // R2 frozen dead-time
    do_wr(A_CTL, 32'h0000_0022, 4'b0001);
    expect_at(0, 32'h11, "R2"); expect_at(15, 1, "R8"); expect_at(16, 1, "R9");
    expect_at(15, 0, "R8", 1); expect_at(16, 1, "R9", 1);
    repeat (2) @(negedge clk);

    // R8 equal write not rejected, clearing break enable rejected
    do_wr(A_CTL, 32'h0000_7011, 4'b0011);
    expect_at(15, 0, "R8");
    do_wr(A_CTL, 32'h0000_6011, 4'b0011);
    expect_at(1, 1, "R2"); expect_at(15, 1, "R8");

    // R6 mixed word at level 1
    do_wr(A_IDLE, 32'h0000_0000, 4'b0011);
    expect_at(4, 4'hA, "R6"); expect_at(5, 4'h5, "R6");
    expect_at(6, 0, "R6"); expect_at(7, 0, "R6"); expect_at(15, 1, "R6");

    // R1 second level write ignored
    do_wr(A_CTL, 32'h0300_0000, 4'b1000);
    expect_at(14, 1, "R1"); expect_at(15, 1, "R1");

    // R3 below level 2: polarity and clock bits free
    do_wr(A_POL, 32'h0, 4'b0001);
    expect_at(8, 0, "R3"); expect_at(9, 0, "R3"); expect_at(15, 0, "R3");
    do_wr(A_CLK, 32'h1, 4'b0001);
    expect_at(12, 1, "R5");
    do_wr(A_CLK, 32'h0, 4'b0001);
    expect_at(12, 0, "R5"); expect_at(15, 0, "R5");

    // R9 write 0 keeps, write 1 clears
    do_wr(A_STAT, 32'h0, 4'b0001);
    expect_at(16, 1, "R9");
    do_wr(A_STAT, 32'h1, 4'b0001);
    expect_at(16, 0, "R9");

    // R10 timer reset
    pulse(1'b0);
    expect_at(0, 0, "R10"); expect_at(14, 0, "R10"); expect_at(1, 0, "R10");
    expect_at(4, 0, "R10"); expect_at(10, 0, "R10"); expect_at(16, 0, "R10");

    // R12 writing 00 uses the single write
    do_wr(A_CTL, 32'h0, 4'b1000);
    expect_at(14, 0, "R12"); expect_at(15, 0, "R12");
    do_wr(A_CTL, 32'h0300_0000, 4'b1000);
    expect_at(14, 0, "R12"); expect_at(15, 1, "R12");
    do_wr(A_CTL, 32'h33, 4'b0001);
    expect_at(0, 32'h33, "R12"); expect_at(15, 0, "R12");

    // level 2
    pulse(1'b0);
    do_wr(A_CLK, 32'h1, 4'b0001);
    do_wr(A_POL, 32'h81, 4'b0001);
    do_wr(A_CTL, 32'h0200_0000, 4'b1000);
    expect_at(14, 2, "R3");
    do_wr(A_CLK, 32'h2, 4'b0001);
    expect_at(12, 1, "R5"); expect_at(13, 1, "R5"); expect_at(15, 1, "R5");
    do_wr(A_CLK, 32'h3, 4'b0001);
    expect_at(15, 0, "R5");
    do_wr(A_POL, 32'h0, 4'b0001);
    expect_at(8, 4'h1, "R3"); expect_at(9, 4'h8, "R3"); expect_at(15, 1, "R3");
    do_wr(A_IDLE, 32'h300, 4'b0010);
    expect_at(6, 0, "R3"); expect_at(7, 0, "R3"); expect_at(15, 1, "R3");
    do_wr(A_CH, 32'h5, 4'b0001);
    expect_at(10, 12'h005, "R4"); expect_at(15, 0, "R4");
    do_wr(A_CTL, 32'h44, 4'b0001);
    expect_at(0, 0, "R2"); expect_at(15, 1, "R2");

    // level 3 after system reset
    pulse(1'b1);
    do_wr(A_CH, 32'h0D, 4'b0001);
    do_wr(A_CTL, 32'h0300_0000, 4'b1000);
    expect_at(14, 3, "R4"); expect_at(10, 12'h005, "R4"); expect_at(11, 4'h1, "R4");
    do_wr(A_CH, 32'h2, 4'b0001);
    expect_at(10, 12'h005, "R4"); expect_at(11, 4'h1, "R4"); expect_at(15, 1, "R4");
    do_wr(A_CH, 32'h0200_000D, 4'b1001);
    expect_at(10, 12'h005, "R4"); expect_at(15, 1, "R4");

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule